// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches each port's word address and active-low enable. When both ports are enabled on the same word, it flags exactly one of them as busy. The flagged port is the one whose request settled last. An active-low busy output per port carries the result. Each port also has a write-enable input, and the block returns a write-commit strobe that the memory array may act on. A busy port never receives a commit strobe.

Arrival order is judged in clock cycles. Each port's address and enable are registered, and a port counts as having "arrived" in the cycle where either of them changed. If both ports change in the same cycle, the right port is flagged. Once a collision is flagged, the flag stays on the same port until the addresses stop matching or an enable drops.

A static strap selects between two modes. In master mode the block computes the busy flags itself. In slave mode the flags come from outside on the busy-input pins and are passed through unchanged, with the same latency. In both modes an asserted busy blocks that port's writes. Every output is registered. An input change reaches the outputs two clock edges after it is applied.

Top module: `dp_collision_arbiter`

## Requirements
- R1: While `rst` is high, and immediately after it, both busy outputs are 1 (not busy) and both write strobes are 0.
- R2: In master mode, if either enable input is 1 (port disabled), both busy outputs are 1.
- R3: In master mode, with both enables at 0 and different addresses (for example 0 and 2047), both busy outputs are 1.
- R4: In master mode, with both enables at 0 and equal addresses, the port whose address or enable changed in the later cycle has busy driven to 0. The other port's busy is 1.
- R5: In master mode, when both ports' address-or-enable change in the same cycle and produce a match, the right port's busy is 0 and the left port's busy is 1.
- R6: In master mode, the two busy outputs are never 0 at the same time.
- R7: A flagged busy holds while the match persists and neither address nor enable changes; a write-enable change alone does not move it. It is released when the addresses differ or an enable goes to 1.
- R8: In slave mode, each busy output equals that port's busy input (0 = busy) as sampled two edges earlier, and both may be 0 together.
- R9: A port's write strobe is 1 exactly when its enable and write enable (both active-low, 0 = active) were 0 and its new busy value is 1. A busy port (busy = 0) never has its strobe at 1.
- R10: An input change affects the outputs only after the second rising clock edge following it; after the first edge the outputs still show the old result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = compute busy flags, 0 = pass busy inputs through; static |
| l_addr | input | ADDR_W (11) | Left port word address |
| l_en_n | input | 1 | Left port enable, active low |
| l_we_n | input | 1 | Left port write enable, active low |
| l_busy_in_n | input | 1 | Left busy input used in slave mode, active low |
| r_addr | input | ADDR_W (11) | Right port word address |
| r_en_n | input | 1 | Right port enable, active low |
| r_we_n | input | 1 | Right port write enable, active low |
| r_busy_in_n | input | 1 | Right busy input used in slave mode, active low |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_go | output | 1 | Left write commit strobe, active high |
| r_wr_go | output | 1 | Right write commit strobe, active high |

## Verification
The assertions assume that `master_mode` is a strap. It is treated as changing only while `rst` is high, because each output is compared with the registered inputs of the cycle before under the present mode. The stimulus therefore selects the mode only inside a reset sequence. It changes port inputs on the falling edge only, so arrival order is defined by whole cycles. Same-cycle changes on both ports are made on purpose to exercise the right-port tie rule.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam int NPORTS = 2;
  localparam int PL     = 0;
  localparam int PR     = 1;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Later arrival loses; a change on both sides in one cycle goes to the right.
  function automatic owner_e pick_owner(input logic chg_l, input logic chg_r,
                                        input logic left_last);
    if (chg_r) return OWN_RIGHT;
    if (chg_l) return OWN_LEFT;
    return left_last ? OWN_LEFT : OWN_RIGHT;
  endfunction

endpackage

// File: rtl/dpc_port_stage.sv
module dpc_port_stage #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_n_i,
  input  logic              we_n_i,
  input  logic              busy_in_n_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              en_q,
  output logic              we_q,
  output logic              bsy_q,
  output logic              chg_q
);

  logic en_i;
  logic moved;

  assign en_i  = ~en_n_i;
  assign moved = (addr_i != addr_q) || (en_i != en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      en_q   <= 1'b0;
      we_q   <= 1'b0;
      bsy_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      addr_q <= addr_i;
      en_q   <= en_i;
      we_q   <= ~we_n_i;
      bsy_q  <= ~busy_in_n_i;
      chg_q  <= moved;
    end
  end

endmodule

// File: rtl/dpc_match.sv
module dpc_match #(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              en_l,
  input  logic              en_r,
  output logic              hit
);

  always_comb begin
    hit = en_l && en_r && (addr_l == addr_r);
  end

endmodule

// File: rtl/dpc_busy_owner.sv
module dpc_busy_owner
  import dpc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic master_mode,
  input  logic hit,
  input  logic chg_l,
  input  logic chg_r,
  input  logic en_l,
  input  logic en_r,
  input  logic we_l,
  input  logic we_r,
  input  logic bsy_l,
  input  logic bsy_r,
  output logic l_busy_n,
  output logic r_busy_n,
  output logic l_wr_go,
  output logic r_wr_go
);

  owner_e own_q, own_d;
  logic   left_last_q;
  logic   busy_l_d, busy_r_d;

  always_comb begin
    if (!hit) begin
      own_d = OWN_NONE;
    end else if (own_q == OWN_NONE || chg_l || chg_r) begin
      own_d = pick_owner(chg_l, chg_r, left_last_q);
    end else begin
      own_d = own_q;
    end
  end

  always_comb begin
    if (master_mode) begin
      busy_l_d = (own_d == OWN_LEFT);
      busy_r_d = (own_d == OWN_RIGHT);
    end else begin
      busy_l_d = bsy_l;
      busy_r_d = bsy_r;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q       <= OWN_NONE;
      left_last_q <= 1'b0;
      l_busy_n    <= 1'b1;
      r_busy_n    <= 1'b1;
      l_wr_go     <= 1'b0;
      r_wr_go     <= 1'b0;
    end else begin
      own_q <= master_mode ? own_d : OWN_NONE;
      if (chg_r) begin
        left_last_q <= 1'b0;
      end else if (chg_l) begin
        left_last_q <= 1'b1;
      end
      l_busy_n <= ~busy_l_d;
      r_busy_n <= ~busy_r_d;
      l_wr_go  <= en_l && we_l && !busy_l_d;
      r_wr_go  <= en_r && we_r && !busy_r_d;
    end
  end

endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_en_n,
  input  logic              l_we_n,
  input  logic              l_busy_in_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_en_n,
  input  logic              r_we_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_go,
  output logic              r_wr_go
);

  logic [ADDR_W-1:0] addr_in [NPORTS];
  logic              en_n_in [NPORTS];
  logic              we_n_in [NPORTS];
  logic              bin_n_in[NPORTS];

  logic [ADDR_W-1:0] addr_q  [NPORTS];
  logic              en_q    [NPORTS];
  logic              we_q    [NPORTS];
  logic              bsy_q   [NPORTS];
  logic              chg_q   [NPORTS];
  logic              hit;

  assign addr_in[PL]  = l_addr;
  assign addr_in[PR]  = r_addr;
  assign en_n_in[PL]  = l_en_n;
  assign en_n_in[PR]  = r_en_n;
  assign we_n_in[PL]  = l_we_n;
  assign we_n_in[PR]  = r_we_n;
  assign bin_n_in[PL] = l_busy_in_n;
  assign bin_n_in[PR] = r_busy_in_n;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    dpc_port_stage #(.ADDR_W(ADDR_W)) u_stage (
      .clk        (clk),
      .rst        (rst),
      .addr_i     (addr_in[p]),
      .en_n_i     (en_n_in[p]),
      .we_n_i     (we_n_in[p]),
      .busy_in_n_i(bin_n_in[p]),
      .addr_q     (addr_q[p]),
      .en_q       (en_q[p]),
      .we_q       (we_q[p]),
      .bsy_q      (bsy_q[p]),
      .chg_q      (chg_q[p])
    );
  end

  dpc_match #(.ADDR_W(ADDR_W)) u_match (
    .addr_l(addr_q[PL]),
    .addr_r(addr_q[PR]),
    .en_l  (en_q[PL]),
    .en_r  (en_q[PR]),
    .hit   (hit)
  );

  dpc_busy_owner u_owner (
    .clk        (clk),
    .rst        (rst),
    .master_mode(master_mode),
    .hit        (hit),
    .chg_l      (chg_q[PL]),
    .chg_r      (chg_q[PR]),
    .en_l       (en_q[PL]),
    .en_r       (en_q[PR]),
    .we_l       (we_q[PL]),
    .we_r       (we_q[PR]),
    .bsy_l      (bsy_q[PL]),
    .bsy_r      (bsy_q[PR]),
    .l_busy_n   (l_busy_n),
    .r_busy_n   (r_busy_n),
    .l_wr_go    (l_wr_go),
    .r_wr_go    (r_wr_go)
  );

endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              master_mode,
  input logic [ADDR_W-1:0] addr_lq,
  input logic [ADDR_W-1:0] addr_rq,
  input logic              en_lq,
  input logic              en_rq,
  input logic              bsy_lq,
  input logic              bsy_rq,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_go,
  input logic              r_wr_go
);

  // R6: never both busy in master mode
  a_r6_never_both_busy: assert property (@(posedge clk) disable iff (rst)
    master_mode |-> (l_busy_n || r_busy_n));

  // R2: a disabled port frees both flags
  a_r2_disabled_frees: assert property (@(posedge clk) disable iff (rst)
    (master_mode && (!$past(en_lq) || !$past(en_rq))) |-> (l_busy_n && r_busy_n));

  // R3: distinct addresses free both flags
  a_r3_distinct_frees: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(en_lq && en_rq && (addr_lq != addr_rq)))
      |-> (l_busy_n && r_busy_n));

  // R4: a match flags exactly one port
  a_r4_one_flagged: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(en_lq && en_rq && (addr_lq == addr_rq)))
      |-> (l_busy_n != r_busy_n));

  // R8: slave pass-through
  a_r8_slave_follow: assert property (@(posedge clk) disable iff (rst)
    !master_mode |-> ((l_busy_n == !$past(bsy_lq)) && (r_busy_n == !$past(bsy_rq))));

  // R9: busy blocks the commit strobe
  a_r9_left_blocked: assert property (@(posedge clk) disable iff (rst)
    !l_busy_n |-> !l_wr_go);

  a_r9_right_blocked: assert property (@(posedge clk) disable iff (rst)
    !r_busy_n |-> !r_wr_go);

endmodule

bind dp_collision_arbiter dpc_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .master_mode(master_mode),
  .addr_lq    (addr_q[0]),
  .addr_rq    (addr_q[1]),
  .en_lq      (en_q[0]),
  .en_rq      (en_q[1]),
  .bsy_lq     (bsy_q[0]),
  .bsy_rq     (bsy_q[1]),
  .l_busy_n   (l_busy_n),
  .r_busy_n   (r_busy_n),
  .l_wr_go    (l_wr_go),
  .r_wr_go    (r_wr_go)
);

// File: tb/tb_dp_collision_arbiter.sv
`timescale 1ns/1ps
module tb_dp_collision_arbiter;

  localparam int ADDR_W = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              master_mode = 1'b1;
  logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
  logic              l_en_n = 1'b1, r_en_n = 1'b1;
  logic              l_we_n = 1'b1, r_we_n = 1'b1;
  logic              l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic              l_busy_n, r_busy_n, l_wr_go, r_wr_go;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  dp_collision_arbiter #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .l_addr(l_addr), .l_en_n(l_en_n), .l_we_n(l_we_n), .l_busy_in_n(l_busy_in_n),
    .r_addr(r_addr), .r_en_n(r_en_n), .r_we_n(r_we_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_go(l_wr_go), .r_wr_go(r_wr_go)
  );

  task automatic chk_busy(input string tag, input logic el, input logic er);
    checks++;
    if (l_busy_n !== el || r_busy_n !== er) begin
      failures++;
      $display("FAIL %s busy l=%b r=%b expected l=%b r=%b", tag, l_busy_n, r_busy_n, el, er);
    end
  endtask

  task automatic chk_wr(input string tag, input logic el, input logic er);
    checks++;
    if (l_wr_go !== el || r_wr_go !== er) begin
      failures++;
      $display("FAIL %s wr l=%b r=%b expected l=%b r=%b", tag, l_wr_go, r_wr_go, el, er);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    l_addr = '0; r_addr = '0; l_en_n = 1'b1; r_en_n = 1'b1;
    l_we_n = 1'b1; r_we_n = 1'b1; l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1;
    idle_inputs();
    master_mode = mode;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_busy("R1 in reset", 1'b1, 1'b1);
    chk_wr("R1 in reset", 1'b0, 1'b0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_busy("R1 after reset", 1'b1, 1'b1);
    chk_wr("R1 after reset", 1'b0, 1'b0);
  endtask

  task automatic t_single_and_later();
    l_addr = 11'd5; l_en_n = 1'b0;
    settle();
    chk_busy("R2 right disabled", 1'b1, 1'b1);
    r_addr = 11'd5; r_en_n = 1'b0;
    settle();
    chk_busy("R4 right arrives later", 1'b1, 1'b0);
    // write enables only: no change of arrival, flag holds
    l_we_n = 1'b0; r_we_n = 1'b0;
    settle();
    chk_busy("R7 hold across write enable", 1'b1, 1'b0);
    chk_wr("R9 busy right blocked", 1'b1, 1'b0);
    l_we_n = 1'b1; r_we_n = 1'b1;
    l_en_n = 1'b1;
    settle();
    chk_busy("R7 release on disable", 1'b1, 1'b1);
    l_en_n = 1'b0;
    settle();
    chk_busy("R4 left arrives later", 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk_busy("R7 hold while stable", 1'b0, 1'b1);
  endtask

  task automatic t_mismatch();
    l_addr = 11'd0; r_addr = 11'd2047;
    l_we_n = 1'b0; r_we_n = 1'b0;
    settle();
    chk_busy("R3 distinct edge addresses", 1'b1, 1'b1);
    chk_wr("R9 both commit", 1'b1, 1'b1);
    l_we_n = 1'b1; r_we_n = 1'b1;
  endtask

  task automatic t_tie_and_latency();
    l_en_n = 1'b1; r_en_n = 1'b1;
    settle();
    chk_busy("R2 both disabled", 1'b1, 1'b1);
    l_addr = 11'd2047; r_addr = 11'd2047; l_en_n = 1'b0; r_en_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_busy("R10 one edge later unchanged", 1'b1, 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk_busy("R5 same-cycle tie to right", 1'b1, 1'b0);
  endtask

  task automatic t_move();
    r_addr = 11'd100;
    settle();
    chk_busy("R7 release on mismatch", 1'b1, 1'b1);
    l_addr = 11'd100;
    settle();
    chk_busy("R4 left moves onto right", 1'b0, 1'b1);
    l_we_n = 1'b0;
    settle();
    chk_wr("R9 busy left blocked", 1'b0, 1'b0);
    l_we_n = 1'b1;
  endtask

  task automatic t_slave();
    l_addr = 11'd7; r_addr = 11'd7; l_en_n = 1'b0; r_en_n = 1'b0;
    settle();
    chk_busy("R8 idle busy inputs", 1'b1, 1'b1);
    l_busy_in_n = 1'b0; l_we_n = 1'b0; r_we_n = 1'b0;
    settle();
    chk_busy("R8 left busy input", 1'b0, 1'b1);
    chk_wr("R9 slave left blocked", 1'b0, 1'b1);
    r_busy_in_n = 1'b0;
    settle();
    chk_busy("R8 both busy inputs", 1'b0, 1'b0);
    chk_wr("R9 slave both blocked", 1'b0, 1'b0);
    l_busy_in_n = 1'b1;
    settle();
    chk_busy("R8 right busy input", 1'b1, 1'b0);
    chk_wr("R9 slave right blocked", 1'b1, 1'b0);
  endtask

  initial begin
    do_reset(1'b1);
    t_single_and_later();
    t_mismatch();
    t_tie_and_latency();
    t_move();
    do_reset(1'b0);
    t_slave();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule